// File: doc/BRIEF.md
# Half-Buffer Ownership Semaphore

This block arbitrates an accumulator array shared between a math producer and a pack consumer. A small counter records how many halves hold finished results that are still waiting to be packed. The producer may not start a new half while the counter is at its limit. The consumer may not start reading while the counter is empty. The limit is set at run time: a limit of 2 lets the producer fill one half while the consumer drains the other, and a limit of 1 makes the two sides share the whole array in turn.

Each side keeps its own half pointer and turns it into a base-row offset for its address generator. The offset is half the array in the 16-bit row view and a quarter of it in the 32-bit view. When the consumer finishes with a half, the block emits a one-cycle request to invalidate that half, or the whole array when the two sides share it.

Top module: `acc_half_sync`

## Requirements
- R1: After a synchronous reset the limit is 2, the count is 0, both half pointers and both bases are 0, and the clear and error outputs are low.
- R2: An init pulse sets the limit (1 when `init_full`=1, else 2) and the row view (`init_wide`=1 selects the 32-bit view), sets the count to 0 and both half pointers to 0, and ignores `prod_done`/`cons_done` in that cycle without an error.
- R3: `prod_stall` is high exactly when the count equals the limit. `cons_stall` is high exactly when the count is 0.
- R4: An accepted post (`prod_done` with the count below the limit) raises the count by one in the next cycle. An accepted get (`cons_done` with the count above 0) lowers it by one.
- R5: Post and get in the same cycle are each judged against the count before that cycle. If both are accepted, the count is unchanged.
- R6: With a limit of 2, an accepted post toggles `prod_half` and an accepted get toggles `cons_half`. With a limit of 1, both pointers stay 0.
- R7: A base is 0 when its pointer is 0. When the pointer is 1, the base is ROWS/2 (512) in the 16-bit view and ROWS/4 (256) in the 32-bit view.
- R8: The cycle after an accepted get, `clr_vld` is 1 for one cycle. `clr_half` then gives the consumer pointer from before the toggle, and `clr_full` is 1 when the limit is 1.
- R9: A post at the limit or a get at 0 is ignored: the count and the pointers hold, and `err` is high for the following cycle.
- R10: With a limit of 2, after one post the producer points at half 1 while the consumer points at half 0, and neither side stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_vld | input | 1 | Load the limit and the view, and clear the count and the pointers |
| init_full | input | 1 | 1 sets limit 1 (whole array shared), 0 sets limit 2 |
| init_wide | input | 1 | 1 selects the 32-bit row view for base offsets |
| prod_done | input | 1 | Producer has finished a half (post) |
| cons_done | input | 1 | Consumer has finished a half (get) |
| prod_stall | output | 1 | Count equals the limit |
| cons_stall | output | 1 | Count is zero |
| sem_value | output | CNT_W | Current count |
| prod_half | output | 1 | Producer half pointer |
| cons_half | output | 1 | Consumer half pointer |
| prod_base | output | ROW_W | Producer base-row offset |
| cons_base | output | ROW_W | Consumer base-row offset |
| clr_vld | output | 1 | One-cycle invalidate request |
| clr_full | output | 1 | Request covers the whole array |
| clr_half | output | 1 | Half to invalidate |
| err | output | 1 | Previous cycle had a rejected post or get |

## Verification
The assertions take for granted that `init_vld` carries a limit of 1 or 2 and that reset is held for at least one edge before any pulse arrives. They also assume that `prod_done` and `cons_done` may arrive in any state, including illegal ones. The stimulus keeps to these assumptions: it only drives init through the two mode bits. It deliberately sends posts at the limit, gets at zero, and simultaneous pairs at the count's boundaries, so that the rejection paths and the bound check taken against the prior count are exercised.

// File: rtl/hsync_pkg.sv
package hsync_pkg;
  typedef enum logic {SYNC_PINGPONG = 1'b0, SYNC_SHARED = 1'b1} sync_mode_e;
  typedef enum logic {VIEW_16B = 1'b0, VIEW_32B = 1'b1} row_view_e;

  function automatic int unsigned limit_of(sync_mode_e m);
    return (m == SYNC_SHARED) ? 1 : 2;
  endfunction
endpackage

// File: rtl/hsync_sem.sv
module hsync_sem #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_vld,
  input  logic [CNT_W-1:0] init_max,
  input  logic             post_req,
  input  logic             get_req,
  output logic [CNT_W-1:0] value,
  output logic             at_max,
  output logic             at_zero,
  output logic             post_ok,
  output logic             get_ok,
  output logic             err
);
  localparam logic [CNT_W-1:0] RST_MAX = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] max_q;

  always_comb begin
    at_max  = (value == max_q);
    at_zero = (value == '0);
    post_ok = post_req && !at_max  && !init_vld;
    get_ok  = get_req  && !at_zero && !init_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q <= RST_MAX;
      value <= '0;
      err   <= 1'b0;
    end else if (init_vld) begin
      max_q <= init_max;
      value <= '0;
      err   <= 1'b0;
    end else begin
      err <= (post_req && !post_ok) || (get_req && !get_ok);
      if (post_ok && !get_ok)
        value <= value + ONE;
      else if (get_ok && !post_ok)
        value <= value - ONE;
    end
  end

  AST_VALUE_LE_MAX: assert property (@(posedge clk) disable iff (rst)
    value <= max_q); // R3
  AST_POST_INC: assert property (@(posedge clk) disable iff (rst)
    (post_req && !get_req && !init_vld && !at_max) |=> (value == $past(value) + ONE)); // R4
  AST_GET_DEC: assert property (@(posedge clk) disable iff (rst)
    (get_req && !post_req && !init_vld && !at_zero) |=> (value == $past(value) - ONE)); // R4
  AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (post_req && get_req && !init_vld && !at_zero && !at_max) |=> $stable(value)); // R5
  AST_POST_AT_MAX_ERR: assert property (@(posedge clk) disable iff (rst)
    (post_req && !get_req && !init_vld && at_max) |=> (err && $stable(value))); // R9
  AST_GET_AT_ZERO_ERR: assert property (@(posedge clk) disable iff (rst)
    (get_req && !post_req && !init_vld && at_zero) |=> (err && $stable(value))); // R9
endmodule

// File: rtl/hsync_side.sv
module hsync_side #(
  parameter int ROWS  = 1024,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_vld,
  input  logic             shared_mode,
  input  logic             wide_view,
  input  logic             advance,
  output logic             half,
  output logic [ROW_W-1:0] base
);
  localparam logic [ROW_W-1:0] HALF_16 = ROW_W'(ROWS / 2);
  localparam logic [ROW_W-1:0] HALF_32 = ROW_W'(ROWS / 4);

  always_ff @(posedge clk) begin
    if (rst || init_vld)
      half <= 1'b0;
    else if (advance && !shared_mode)
      half <= ~half;
  end

  always_comb begin
    if (!half)
      base = '0;
    else if (wide_view)
      base = HALF_32;
    else
      base = HALF_16;
  end

  AST_HALF_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (advance && !shared_mode && !init_vld) |=> (half != $past(half))); // R6
  AST_SHARED_PINNED: assert property (@(posedge clk) disable iff (rst)
    shared_mode |-> !half); // R6
endmodule

// File: rtl/acc_half_sync.sv
module acc_half_sync #(
  parameter int ROWS  = 1024,
  parameter int CNT_W = 2,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_vld,
  input  logic             init_full,
  input  logic             init_wide,
  input  logic             prod_done,
  input  logic             cons_done,
  output logic             prod_stall,
  output logic             cons_stall,
  output logic [CNT_W-1:0] sem_value,
  output logic             prod_half,
  output logic             cons_half,
  output logic [ROW_W-1:0] prod_base,
  output logic [ROW_W-1:0] cons_base,
  output logic             clr_vld,
  output logic             clr_full,
  output logic             clr_half,
  output logic             err
);
  import hsync_pkg::*;

  localparam int SIDES = 2;

  sync_mode_e       mode_q;
  row_view_e        view_q;
  logic [CNT_W-1:0] init_max;
  logic             post_ok, get_ok;
  logic [SIDES-1:0] adv_v;
  logic [SIDES-1:0] half_v;
  logic [ROW_W-1:0] base_v [SIDES];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SYNC_PINGPONG;
      view_q <= VIEW_16B;
    end else if (init_vld) begin
      mode_q <= init_full ? SYNC_SHARED : SYNC_PINGPONG;
      view_q <= init_wide ? VIEW_32B : VIEW_16B;
    end
  end

  always_comb init_max = CNT_W'(limit_of(init_full ? SYNC_SHARED : SYNC_PINGPONG));

  hsync_sem #(.CNT_W(CNT_W)) u_sem (
    .clk      (clk),
    .rst      (rst),
    .init_vld (init_vld),
    .init_max (init_max),
    .post_req (prod_done),
    .get_req  (cons_done),
    .value    (sem_value),
    .at_max   (prod_stall),
    .at_zero  (cons_stall),
    .post_ok  (post_ok),
    .get_ok   (get_ok),
    .err      (err)
  );

  assign adv_v = {get_ok, post_ok};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    hsync_side #(.ROWS(ROWS), .ROW_W(ROW_W)) u_side (
      .clk         (clk),
      .rst         (rst),
      .init_vld    (init_vld),
      .shared_mode (mode_q == SYNC_SHARED),
      .wide_view   (view_q == VIEW_32B),
      .advance     (adv_v[s]),
      .half        (half_v[s]),
      .base        (base_v[s])
    );
  end

  assign prod_half = half_v[0];
  assign cons_half = half_v[1];
  assign prod_base = base_v[0];
  assign cons_base = base_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_vld  <= 1'b0;
      clr_full <= 1'b0;
      clr_half <= 1'b0;
    end else begin
      clr_vld  <= get_ok;
      clr_full <= (mode_q == SYNC_SHARED);
      clr_half <= half_v[1];
    end
  end

  AST_CLEAR_AFTER_GET: assert property (@(posedge clk) disable iff (rst)
    (cons_done && !init_vld && !cons_stall) |=> clr_vld); // R8
  AST_CLEAR_HALF_OLD: assert property (@(posedge clk) disable iff (rst)
    (cons_done && !init_vld && !cons_stall) |=> (clr_half == $past(cons_half))); // R8
  AST_NO_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cons_done |=> !clr_vld); // R8
  AST_SPLIT_OWNERSHIP: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SYNC_PINGPONG && sem_value == CNT_W'(1)) |-> (!prod_stall && !cons_stall)); // R10
endmodule

// File: tb/acc_half_sync_test.sv
`timescale 1ns/1ps
module acc_half_sync_test;
  localparam int ROWS  = 1024;
  localparam int CNT_W = 2;
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_vld = 0, init_full = 0, init_wide = 0, prod_done = 0, cons_done = 0;
  logic prod_stall, cons_stall, prod_half, cons_half, clr_vld, clr_full, clr_half, err;
  logic [CNT_W-1:0] sem_value;
  logic [ROW_W-1:0] prod_base, cons_base;

  always #4 clk = ~clk;

  acc_half_sync #(.ROWS(ROWS), .CNT_W(CNT_W)) uut (.*);

  typedef struct {
    string note;
    int val, pst, cst, ph, ch, pb, cb, cv, cf, chh, er;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int errors = 0, checks = 0;
  bit finished = 0;

  int m_max = 2, m_val = 0, m_ph = 0, m_ch = 0, m_full = 0, m_wide = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int base_of(int h);
    if (h == 0) return 0;
    return m_wide ? ROWS / 4 : ROWS / 2;
  endfunction

  task automatic step(string note, bit ini, bit inf, bit inw, bit p, bit c);
    exp_t x;
    bit pok, gok;
    @(negedge clk);
    init_vld = ini; init_full = inf; init_wide = inw; prod_done = p; cons_done = c;
    pok = p && !ini && (m_val != m_max);
    gok = c && !ini && (m_val != 0);
    x.note = note;
    x.cv = 0; x.cf = 0; x.chh = 0; x.er = 0;
    if (ini) begin
      m_max = inf ? 1 : 2; m_val = 0; m_ph = 0; m_ch = 0; m_full = inf; m_wide = inw;
    end else begin
      x.er = ((p && !pok) || (c && !gok)) ? 1 : 0;
      x.cv = gok; x.chh = m_ch; x.cf = m_full;
      if (pok && !gok) m_val++;
      if (gok && !pok) m_val--;
      if (pok && !m_full) m_ph ^= 1;
      if (gok && !m_full) m_ch ^= 1;
    end
    x.val = m_val; x.pst = (m_val == m_max); x.cst = (m_val == 0);
    x.ph = m_ph; x.ch = m_ch; x.pb = base_of(m_ph); x.cb = base_of(m_ch);
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R4", {"count after ", e.note}, int'(sem_value), e.val);
      chk("R3", {"producer stall after ", e.note}, int'(prod_stall), e.pst);
      chk("R3", {"consumer stall after ", e.note}, int'(cons_stall), e.cst);
      chk("R6", {"producer half after ", e.note}, int'(prod_half), e.ph);
      chk("R6", {"consumer half after ", e.note}, int'(cons_half), e.ch);
      chk("R7", {"producer base after ", e.note}, int'(prod_base), e.pb);
      chk("R7", {"consumer base after ", e.note}, int'(cons_base), e.cb);
      chk("R8", {"clear valid after ", e.note}, int'(clr_vld), e.cv);
      if (e.cv != 0) begin
        chk("R8", {"clear half after ", e.note}, int'(clr_half), e.chh);
        chk("R8", {"clear full after ", e.note}, int'(clr_full), e.cf);
      end
      chk("R9", {"error flag after ", e.note}, int'(err), e.er);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "reset count", int'(sem_value), 0);
    chk("R1", "reset producer stall", int'(prod_stall), 0);
    chk("R1", "reset consumer stall", int'(cons_stall), 1);
    chk("R1", "reset halves", int'({prod_half, cons_half}), 0);
    chk("R1", "reset bases", int'(prod_base) + int'(cons_base), 0);
    chk("R1", "reset clear/err", int'({clr_vld, err}), 0);

    step("R1 idle", 0, 0, 0, 0, 0);
    step("R9 get at zero", 0, 0, 0, 0, 1);
    step("R10 first post", 0, 0, 0, 1, 0);
    step("R4 second post", 0, 0, 0, 1, 0);
    step("R9 post at limit", 0, 0, 0, 1, 0);
    step("R8 get half0", 0, 0, 0, 0, 1);
    step("R5 post+get mid", 0, 0, 0, 1, 1);
    step("R8 get half1", 0, 0, 0, 0, 1);
    step("R2 init pingpong wide with pulses", 1, 0, 1, 1, 1);
    step("R7 post wide view", 0, 0, 0, 1, 0);
    step("R7 get wide view", 0, 0, 0, 0, 1);
    step("R2 init shared", 1, 1, 0, 0, 0);
    step("R6 post shared", 0, 0, 0, 1, 0);
    step("R9 post at limit shared", 0, 0, 0, 1, 0);
    step("R8 get shared", 0, 0, 0, 0, 1);
    step("R5 pair at zero", 0, 0, 0, 1, 1);
    step("R5 pair at limit", 0, 0, 0, 1, 1);
    step("R2 init pingpong", 1, 0, 0, 0, 0);
    step("R5 pair at zero pingpong", 0, 0, 0, 1, 1);
    step("R5 pair at one pingpong", 0, 0, 0, 1, 1);
    step("R4 idle tail", 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #3;
    summary();
  end
endmodule